// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block is the control decoder of a single-cycle 32-bit load/store processor. It is purely combinational. It reads the opcode and function fields of the instruction that is executing and the zero flag of the ALU. From these it drives four things:

- the datapath multiplexer selects;
- the register-file and data-memory enables;
- a 4-bit ALU operation code;
- the choice and value of the next program counter.

Decoding is done in two levels. A main decoder looks only at the opcode. It produces the single-bit controls and a 2-bit ALU class. A second decoder combines that class with the function field to form the ALU operation. A third stage builds the candidate PC values from the current PC, the 16-bit immediate and the 26-bit jump index. It picks one of them from the branch flag, the jump flag and the zero flag.

Every single-bit select that drives a two-way multiplexer chooses the multiplexer's 1 input when it is 1 and its 0 input when it is 0.

Top module: `cpu_ctrl_dec`

## Requirements
- R1: Opcode 000000 (register-register) drives reg_dst=1, alu_src=0, mem_to_reg=0, reg_write=1, mem_read=0, mem_write=0, branch=0, jump=0 and alu_class=10.
- R2: Opcode 100011 (load word) drives alu_src=1, mem_to_reg=1, reg_write=1, mem_read=1, reg_dst=0, mem_write=0, branch=0, jump=0 and alu_class=00.
- R3: Opcode 101011 (store word) drives mem_write=1, alu_src=1, reg_write=0, mem_read=0, reg_dst=0, mem_to_reg=0, branch=0, jump=0 and alu_class=00.
- R4: Opcode 000100 (branch-if-equal) drives branch=1, alu_class=01 and zero on every other single-bit control.
- R5: The ALU code is 0010 (add) for class 00 and 0110 (subtract) for class 01. For class 10 it comes from the function field: 100000 gives 0010, 100010 gives 0110, 100100 gives 0000 (AND), 100101 gives 0001 (OR), 101010 gives 0111 (set-on-less-than), and any other function value gives 0010.
- R6: When neither a taken branch nor a jump applies, pc_src=00 and next_pc = pc+4.
- R7: For branch-if-equal with zero_i=1: pc_src=01 and next_pc = pc+4 + (sign-extended imm << 2). With zero_i=0: pc_src=00 and next_pc = pc+4.
- R8: Opcode 000010 (jump) drives jump=1, pc_src=10 and next_pc = {(pc+4)[31:28], jidx, 2'b00}, with every write enable and mem_read at 0.
- R9: Any opcode not listed above drives reg_write, mem_write and mem_read to 0 and selects pc+4.
- R10: zero_i has no effect on any output for any opcode other than branch-if-equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 6 | Instruction opcode field |
| funct_i | input | 6 | Instruction function field |
| zero_i | input | 1 | ALU result-is-zero flag |
| pc_i | input | 32 | Current program counter |
| imm_i | input | 16 | Instruction immediate / branch offset |
| jidx_i | input | 26 | Jump index field |
| reg_dst_o | output | 1 | Destination register select (1 = rd field) |
| alu_src_o | output | 1 | ALU second operand select (1 = immediate) |
| mem_to_reg_o | output | 1 | Write-back select (1 = memory data) |
| reg_write_o | output | 1 | Register file write enable |
| mem_read_o | output | 1 | Data memory read enable |
| mem_write_o | output | 1 | Data memory write enable |
| branch_o | output | 1 | Branch-if-equal decoded |
| jump_o | output | 1 | Jump decoded |
| alu_class_o | output | 2 | ALU class from the main decoder |
| alu_ctrl_o | output | 4 | ALU operation code |
| pc_src_o | output | 2 | Next-PC source: 00 sequential, 01 branch, 10 jump |
| next_pc_o | output | 32 | Next program counter value |

## Verification
Two functions can be active in the same instruction: the branch decision and the ALU operation decode. A branch-if-equal can arrive with a function field that holds a valid register-register code. The ALU code must then stay at subtract while zero_i alone moves the PC between pc+4 and the branch target. The bench provokes this by driving branch opcodes with every function code and both zero values. It also asserts zero_i on every other opcode. A behavioural reference model, evaluated after the inputs settle, judges all outputs for each vector.

// File: rtl/cpu_ctrl_pkg.sv
package cpu_ctrl_pkg;
  localparam int OP_W   = 6;
  localparam int FN_W   = 6;
  localparam int XLEN   = 32;
  localparam int IMM_W  = 16;
  localparam int JIDX_W = 26;
  localparam int AC_W   = 4;

  localparam logic [OP_W-1:0] OP_RTYPE = 6'b000000;
  localparam logic [OP_W-1:0] OP_LW    = 6'b100011;
  localparam logic [OP_W-1:0] OP_SW    = 6'b101011;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'b000100;
  localparam logic [OP_W-1:0] OP_J     = 6'b000010;

  localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
  localparam logic [FN_W-1:0] FN_SUB = 6'b100010;
  localparam logic [FN_W-1:0] FN_AND = 6'b100100;
  localparam logic [FN_W-1:0] FN_OR  = 6'b100101;
  localparam logic [FN_W-1:0] FN_SLT = 6'b101010;

  localparam logic [AC_W-1:0] ALU_AND = 4'b0000;
  localparam logic [AC_W-1:0] ALU_OR  = 4'b0001;
  localparam logic [AC_W-1:0] ALU_ADD = 4'b0010;
  localparam logic [AC_W-1:0] ALU_SUB = 4'b0110;
  localparam logic [AC_W-1:0] ALU_SLT = 4'b0111;

  typedef enum logic [1:0] {
    CLS_ADD   = 2'b00,
    CLS_SUB   = 2'b01,
    CLS_FUNCT = 2'b10
  } alu_class_e;

  typedef enum logic [1:0] {
    PC_SEQ = 2'b00,
    PC_BR  = 2'b01,
    PC_JMP = 2'b10
  } pc_src_e;

  typedef struct packed {
    logic       reg_dst;
    logic       alu_src;
    logic       mem_to_reg;
    logic       reg_write;
    logic       mem_read;
    logic       mem_write;
    logic       branch;
    logic       jump;
    alu_class_e alu_class;
  } ctrl_t;
endpackage

// File: rtl/cpu_ctrl_main_dec.sv
module cpu_ctrl_main_dec
  import cpu_ctrl_pkg::*;
(
  input  logic [OP_W-1:0] opcode_i,
  output ctrl_t           ctrl_o
);
  always_comb begin
    ctrl_o = '{default: '0, alu_class: CLS_ADD};
    unique case (opcode_i)
      OP_RTYPE: begin
        ctrl_o.reg_dst   = 1'b1;
        ctrl_o.reg_write = 1'b1;
        ctrl_o.alu_class = CLS_FUNCT;
      end
      OP_LW: begin
        ctrl_o.alu_src    = 1'b1;
        ctrl_o.mem_to_reg = 1'b1;
        ctrl_o.reg_write  = 1'b1;
        ctrl_o.mem_read   = 1'b1;
      end
      OP_SW: begin
        ctrl_o.alu_src   = 1'b1;
        ctrl_o.mem_write = 1'b1;
      end
      OP_BEQ: begin
        ctrl_o.branch    = 1'b1;
        ctrl_o.alu_class = CLS_SUB;
      end
      OP_J: ctrl_o.jump = 1'b1;
      default: ;  // unsupported: no side effects, sequential PC
    endcase
  end
endmodule

// File: rtl/cpu_ctrl_alu_dec.sv
module cpu_ctrl_alu_dec
  import cpu_ctrl_pkg::*;
(
  input  alu_class_e      alu_class_i,
  input  logic [FN_W-1:0] funct_i,
  output logic [AC_W-1:0] alu_ctrl_o
);
  logic [AC_W-1:0] fn_op;

  always_comb begin
    unique case (funct_i)
      FN_ADD:  fn_op = ALU_ADD;
      FN_SUB:  fn_op = ALU_SUB;
      FN_AND:  fn_op = ALU_AND;
      FN_OR:   fn_op = ALU_OR;
      FN_SLT:  fn_op = ALU_SLT;
      default: fn_op = ALU_ADD;
    endcase
  end

  always_comb begin
    unique case (alu_class_i)
      CLS_SUB:   alu_ctrl_o = ALU_SUB;
      CLS_FUNCT: alu_ctrl_o = fn_op;
      default:   alu_ctrl_o = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/cpu_ctrl_pc_sel.sv
module cpu_ctrl_pc_sel
  import cpu_ctrl_pkg::*;
#(
  parameter int PC_W  = XLEN,
  parameter int OFF_W = IMM_W,
  parameter int IDX_W = JIDX_W
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [OFF_W-1:0] imm_i,
  input  logic [IDX_W-1:0] jidx_i,
  input  logic             branch_i,
  input  logic             jump_i,
  input  logic             zero_i,
  output pc_src_e          pc_src_o,
  output logic [PC_W-1:0]  next_pc_o
);
  localparam int HI_W  = PC_W - IDX_W - 2;
  localparam int EXT_W = PC_W - OFF_W - 2;

  logic [PC_W-1:0] pc_plus4, br_tgt, jmp_tgt;

  assign pc_plus4 = pc_i + PC_W'(4);
  assign br_tgt   = pc_plus4 + {{EXT_W{imm_i[OFF_W-1]}}, imm_i, 2'b00};
  assign jmp_tgt  = {pc_plus4[PC_W-1 -: HI_W], jidx_i, 2'b00};

  // jump wins over a taken branch (they cannot both decode, but keep a fixed order)
  always_comb begin
    if (jump_i)                pc_src_o = PC_JMP;
    else if (branch_i && zero_i) pc_src_o = PC_BR;
    else                       pc_src_o = PC_SEQ;
  end

  always_comb begin
    unique case (pc_src_o)
      PC_JMP:  next_pc_o = jmp_tgt;
      PC_BR:   next_pc_o = br_tgt;
      default: next_pc_o = pc_plus4;
    endcase
  end
endmodule

// File: rtl/cpu_ctrl_dec.sv
module cpu_ctrl_dec
  import cpu_ctrl_pkg::*;
#(
  parameter int PC_W  = XLEN,
  parameter int OFF_W = IMM_W,
  parameter int IDX_W = JIDX_W
) (
  input  logic [OP_W-1:0]  opcode_i,
  input  logic [FN_W-1:0]  funct_i,
  input  logic             zero_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [OFF_W-1:0] imm_i,
  input  logic [IDX_W-1:0] jidx_i,
  output logic             reg_dst_o,
  output logic             alu_src_o,
  output logic             mem_to_reg_o,
  output logic             reg_write_o,
  output logic             mem_read_o,
  output logic             mem_write_o,
  output logic             branch_o,
  output logic             jump_o,
  output logic [1:0]       alu_class_o,
  output logic [AC_W-1:0]  alu_ctrl_o,
  output logic [1:0]       pc_src_o,
  output logic [PC_W-1:0]  next_pc_o
);
  ctrl_t   ctrl;
  pc_src_e pc_src;

  cpu_ctrl_main_dec u_main (
    .opcode_i (opcode_i),
    .ctrl_o   (ctrl)
  );

  cpu_ctrl_alu_dec u_alu (
    .alu_class_i (ctrl.alu_class),
    .funct_i     (funct_i),
    .alu_ctrl_o  (alu_ctrl_o)
  );

  cpu_ctrl_pc_sel #(
    .PC_W  (PC_W),
    .OFF_W (OFF_W),
    .IDX_W (IDX_W)
  ) u_pc (
    .pc_i      (pc_i),
    .imm_i     (imm_i),
    .jidx_i    (jidx_i),
    .branch_i  (ctrl.branch),
    .jump_i    (ctrl.jump),
    .zero_i    (zero_i),
    .pc_src_o  (pc_src),
    .next_pc_o (next_pc_o)
  );

  assign reg_dst_o    = ctrl.reg_dst;
  assign alu_src_o    = ctrl.alu_src;
  assign mem_to_reg_o = ctrl.mem_to_reg;
  assign reg_write_o  = ctrl.reg_write;
  assign mem_read_o   = ctrl.mem_read;
  assign mem_write_o  = ctrl.mem_write;
  assign branch_o     = ctrl.branch;
  assign jump_o       = ctrl.jump;
  assign alu_class_o  = ctrl.alu_class;
  assign pc_src_o     = pc_src;
endmodule

// File: rtl/cpu_ctrl_dec_chk.sv
module cpu_ctrl_dec_chk
  import cpu_ctrl_pkg::*;
#(
  parameter int PC_W  = XLEN,
  parameter int OFF_W = IMM_W,
  parameter int IDX_W = JIDX_W
) (
  input logic [OP_W-1:0]  opcode_i,
  input logic             zero_i,
  input logic [PC_W-1:0]  pc_i,
  input logic [IDX_W-1:0] jidx_i,
  input logic             reg_dst_o,
  input logic             alu_src_o,
  input logic             mem_to_reg_o,
  input logic             reg_write_o,
  input logic             mem_read_o,
  input logic             mem_write_o,
  input logic             branch_o,
  input logic             jump_o,
  input logic [1:0]       alu_class_o,
  input logic [AC_W-1:0]  alu_ctrl_o,
  input logic [1:0]       pc_src_o,
  input logic [PC_W-1:0]  next_pc_o
);
  logic [PC_W-1:0] pc4;
  logic            known_op;
  assign pc4      = pc_i + PC_W'(4);
  assign known_op = opcode_i inside {OP_RTYPE, OP_LW, OP_SW, OP_BEQ, OP_J};

  always_comb begin
    a_r1_rd_sel_only_rtype: assert (!reg_dst_o || opcode_i == OP_RTYPE);
    a_r2_load_writes_back: assert (opcode_i != OP_LW || (mem_read_o && mem_to_reg_o && reg_write_o && alu_src_o));
    a_r3_store_no_regwrite: assert (!mem_write_o || (!reg_write_o && alu_src_o && opcode_i == OP_SW));
    a_r4_branch_subtracts: assert (!branch_o || (alu_ctrl_o == ALU_SUB && !reg_write_o && !mem_write_o));
    a_r6_seq_pc: assert (pc_src_o != 2'b00 || next_pc_o == pc4);
    a_r7_taken_needs_zero: assert (pc_src_o != 2'b01 || (branch_o && zero_i));
    a_r8_jump_target: assert (!jump_o || (pc_src_o == 2'b10 &&
                              next_pc_o == {pc4[PC_W-1 -: PC_W-IDX_W-2], jidx_i, 2'b00}));
    a_r9_unknown_quiet: assert (known_op || (!reg_write_o && !mem_write_o && !mem_read_o && next_pc_o == pc4));
  end
endmodule

bind cpu_ctrl_dec cpu_ctrl_dec_chk #(
  .PC_W  (PC_W),
  .OFF_W (OFF_W),
  .IDX_W (IDX_W)
) u_chk (
  .opcode_i     (opcode_i),
  .zero_i       (zero_i),
  .pc_i         (pc_i),
  .jidx_i       (jidx_i),
  .reg_dst_o    (reg_dst_o),
  .alu_src_o    (alu_src_o),
  .mem_to_reg_o (mem_to_reg_o),
  .reg_write_o  (reg_write_o),
  .mem_read_o   (mem_read_o),
  .mem_write_o  (mem_write_o),
  .branch_o     (branch_o),
  .jump_o       (jump_o),
  .alu_class_o  (alu_class_o),
  .alu_ctrl_o   (alu_ctrl_o),
  .pc_src_o     (pc_src_o),
  .next_pc_o    (next_pc_o)
);

// File: tb/cpu_ctrl_dec_test.sv
module cpu_ctrl_dec_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic [5:0]  opcode, funct;
  logic        zero;
  logic [31:0] pc;
  logic [15:0] imm;
  logic [25:0] jidx;
  logic        reg_dst, alu_src, mem_to_reg, reg_write, mem_read, mem_write, branch, jump;
  logic [1:0]  alu_class, pc_src;
  logic [3:0]  alu_ctrl;
  logic [31:0] next_pc;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  cpu_ctrl_dec uut (
    .opcode_i (opcode), .funct_i (funct), .zero_i (zero), .pc_i (pc),
    .imm_i (imm), .jidx_i (jidx),
    .reg_dst_o (reg_dst), .alu_src_o (alu_src), .mem_to_reg_o (mem_to_reg),
    .reg_write_o (reg_write), .mem_read_o (mem_read), .mem_write_o (mem_write),
    .branch_o (branch), .jump_o (jump), .alu_class_o (alu_class),
    .alu_ctrl_o (alu_ctrl), .pc_src_o (pc_src), .next_pc_o (next_pc)
  );

  // fields packed as {rd,as,m2r,rw,mr,mw,br,j,cls[2],alu[4],src[2],npc[32]}
  function automatic logic [47:0] model(input logic [5:0] op, input logic [5:0] fn,
                                        input logic z, input logic [31:0] p,
                                        input logic [15:0] im, input logic [25:0] ji);
    logic [7:0]  c = 8'h00;
    logic [1:0]  cls = 2'b00;
    logic [3:0]  alu;
    logic [1:0]  src = 2'b00;
    longint      seq = longint'(p) + 4;
    logic [31:0] npc = seq[31:0];
    case (op)
      6'b000000: begin c = 8'b1001_0000; cls = 2'b10; end // R1
      6'b100011: c = 8'b0111_1000;                        // R2
      6'b101011: c = 8'b0100_0100;                        // R3
      6'b000100: begin c = 8'b0000_0010; cls = 2'b01;     // R4
        if (z) begin                                      // R7
          src = 2'b01;
          npc = npc + 32'(signed'(im)) * 4;
        end
      end
      6'b000010: begin c = 8'b0000_0001; src = 2'b10;     // R8
        npc = {npc[31:28], ji, 2'b00};
      end
      default: ;                                          // R9, R10, R6
    endcase
    if (cls == 2'b00) alu = 4'd2;                         // R5
    else if (cls == 2'b01) alu = 4'd6;
    else case (fn)
      6'd32: alu = 4'd2;
      6'd34: alu = 4'd6;
      6'd36: alu = 4'd0;
      6'd37: alu = 4'd1;
      6'd42: alu = 4'd7;
      default: alu = 4'd2;
    endcase
    return {c, cls, alu, src, npc};
  endfunction

  function automatic string req_of(input logic [5:0] op);
    case (op)
      6'b000000: return "R1/R5/R6";
      6'b100011: return "R2/R6";
      6'b101011: return "R3/R6";
      6'b000100: return "R4/R5/R7";
      6'b000010: return "R8";
      default:   return "R9/R10";
    endcase
  endfunction

  task automatic apply(input logic [5:0] op, input logic [5:0] fn, input logic z,
                       input logic [31:0] p, input logic [15:0] im, input logic [25:0] ji);
    logic [47:0] exp_v, act_v;
    @(posedge clk);
    opcode = op; funct = fn; zero = z; pc = p; imm = im; jidx = ji;
    @(negedge clk);
    exp_v = model(op, fn, z, p, im, ji);
    act_v = {reg_dst, alu_src, mem_to_reg, reg_write, mem_read, mem_write, branch, jump,
             alu_class, alu_ctrl, pc_src, next_pc};
    compared++;
    if (act_v !== exp_v) begin
      mismatched++;
      $display("FAIL %s op=%b fn=%b z=%b act=%h exp=%h", req_of(op), op, fn, z, act_v, exp_v);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [5:0] ops [5] = '{6'b000000, 6'b100011, 6'b101011, 6'b000100, 6'b000010};
    logic [5:0] fns [6] = '{6'd32, 6'd34, 6'd36, 6'd37, 6'd42, 6'd63};
    opcode = '0; funct = '0; zero = 1'b0; pc = '0; imm = '0; jidx = '0;
    // initial all-zero state: R-type, ALU code from funct 0 -> add (R1, R5)
    apply(6'd0, 6'd0, 1'b0, 32'h0, 16'h0, 26'h0);
    // R1..R5, R10: every opcode against every funct and both zero values
    foreach (ops[i]) foreach (fns[k]) for (int z = 0; z < 2; z++)
      apply(ops[i], fns[k], z[0], 32'h0040_1000, 16'h0010, 26'h123_4567);
    // R7 boundaries: negative offset, max positive, PC wrap
    apply(6'b000100, 6'd32, 1'b1, 32'h0000_1000, 16'h8000, 26'h0);
    apply(6'b000100, 6'd32, 1'b1, 32'h0000_1000, 16'h7FFF, 26'h0);
    apply(6'b000100, 6'd0,  1'b1, 32'hFFFF_FFFC, 16'hFFFF, 26'h0);
    apply(6'b000100, 6'd0,  1'b0, 32'hFFFF_FFFC, 16'h0004, 26'h0);
    // R8: upper PC bits come from pc+4, including carry into them
    apply(6'b000010, 6'd0, 1'b0, 32'h1FFF_FFFC, 16'h0, 26'h3FF_FFFF);
    apply(6'b000010, 6'd0, 1'b1, 32'hA000_0000, 16'hFFFF, 26'h0);
    // R9, R10: every opcode value with zero set and clear
    for (int o = 0; o < 64; o++) begin
      apply(6'(o), 6'd42, 1'b1, 32'h0000_2000, 16'hFFF0, 26'h155_5555);
      apply(6'(o), 6'd42, 1'b0, 32'h0000_2000, 16'hFFF0, 26'h155_5555);
    end
    // random mix (R6 sequential flow on most)
    for (int n = 0; n < 2000; n++) begin
      logic [5:0] rop = ($urandom_range(0, 3) == 0) ? 6'($urandom) : ops[$urandom_range(0, 4)];
      logic [5:0] rfn = ($urandom_range(0, 3) == 0) ? 6'($urandom) : fns[$urandom_range(0, 5)];
      apply(rop, rfn, 1'($urandom), $urandom, 16'($urandom), 26'($urandom));
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule